// File: doc/BRIEF.md
# Pattern Match Product-Term Engine

This block watches a bank of digital pins and evaluates a programmable sum-of-products expression over them. Eight slices each pick one pin and test it against one of eight conditions. Some conditions test a level, some test a transition, and two are constants. Consecutive slices are grouped into product terms. A slice whose endpoint flag is set closes a group. The group's value is the AND of every slice from the one after the previous endpoint up to and including the closing slice. The last slice always closes a group.

Every closed product term drives its own registered interrupt bit, at the index of its closing slice. A single registered match output carries the OR of all terms. Transition conditions can be sticky: once they see their edge they stay true until a re-arm strobe clears them. This lets one term require, for example, "pin A is high and pin B has risen at some point since the last re-arm". The engine has no data stream. Every pin is plain control or status, so there is no valid/ready handshake and no back-pressure.

Top module: `pm_minterm_engine`

## Requirements
- R1: Every pin goes through a two-flop synchroniser. A pin change set up before clock edge k shows on `term_irq` and `match_any` after edge k+2. A configuration change shows after the next clock edge.
- R2: Slice s tests only the pin whose index sits in `cfg_sel[s*4 +: 4]`. Changes on other pins have no effect on that slice.
- R3: The 3-bit condition of slice s is `cfg_cond[s*3 +: 3]`, encoded as follows: 0 constant true, 1 sticky rising, 2 sticky falling, 3 sticky either edge, 4 high level, 5 low level, 6 constant false, 7 single-cycle event (either edge).
- R4: A high-level slice is true while its synchronised pin is 1. A low-level slice is true while it is 0.
- R5: A sticky edge slice becomes true when its edge is seen and stays true after the pin returns. A cycle with `rearm` high clears it, and the affected term bit drops after that clock edge.
- R6: An event slice is true only in the single cycle after a pin transition, so a term built from it alone pulses `term_irq` for exactly one cycle.
- R7: Bit i of `term_irq` is the AND of slices j+1..i, where j is the previous slice with its endpoint set, or -1 if there is none. Bits at slices whose endpoint flag is clear stay 0.
- R8: Slice 7 always closes a term, whatever the other endpoint flags are.
- R9: `match_any` equals the OR of all `term_irq` bits in the same cycle.
- R10: A constant-true slice never blocks its term. A constant-false slice keeps its term at 0.
- R11: During and right after reset, `term_irq` and `match_any` are 0 and all sticky latches are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 16 | Asynchronous digital pins |
| cfg_sel | input | 32 | Pin index per slice, 4 bits each |
| cfg_cond | input | 24 | Condition code per slice, 3 bits each |
| cfg_end | input | 7 | Endpoint flags for slices 0..6 |
| rearm | input | 1 | Clears all sticky edge latches |
| term_irq | output | 8 | Registered product-term interrupts, one per closing slice |
| match_any | output | 1 | Registered OR of all product terms |

## Verification
A wrong synchroniser or edge-delay stage moves the output by a cycle or makes an edge test fire on the wrong polarity. Because every check samples at the exact edge the requirements predict, either fault is seen at the first pin toggle. A stuck or never-set sticky latch shows as a term bit that fails to hold after the pin returns, or that survives a re-arm. This is visible within one cycle of the re-arm strobe. A wrong grouping of slices shows as a set bit at a non-endpoint index, or as a term that ignores one of its slices, as soon as that slice's condition differs from its neighbours.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    PM_TRUE   = 3'd0,
    PM_RISE   = 3'd1,
    PM_FALL   = 3'd2,
    PM_EITHER = 3'd3,
    PM_HIGH   = 3'd4,
    PM_LOW    = 3'd5,
    PM_FALSE  = 3'd6,
    PM_EVENT  = 3'd7
  } pm_cond_e;

  localparam int unsigned PM_COND_W = 3;
endpackage

// File: rtl/pm_pin_sync.sv
module pm_pin_sync #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_raw,
  output logic [NPINS-1:0] pin_cur,
  output logic [NPINS-1:0] pin_prev
);
  logic [NPINS-1:0] meta_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[p]   <= 1'b0;
        pin_cur[p]  <= 1'b0;
        pin_prev[p] <= 1'b0;
      end else begin
        meta_q[p]   <= pin_raw[p];
        pin_cur[p]  <= meta_q[p];
        pin_prev[p] <= pin_cur[p];
      end
    end

    // R1
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cur[p] != pin_prev[p]) |-> (pin_prev[p] == $past(pin_cur[p])));
  end
endmodule

// File: rtl/pm_slice.sv
module pm_slice
  import pm_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned SELW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rearm,
  input  logic [NPINS-1:0] pin_cur,
  input  logic [NPINS-1:0] pin_prev,
  input  logic [SELW-1:0]  sel,
  input  pm_cond_e         mode,
  output logic             hit
);
  logic cur_bit, prv_bit, rose, fell, edge_match, latch_q;

  always_comb begin
    cur_bit = 1'b0;
    prv_bit = 1'b0;
    if (32'(sel) < NPINS) begin
      cur_bit = pin_cur[sel];
      prv_bit = pin_prev[sel];
    end
  end

  assign rose = cur_bit & ~prv_bit;
  assign fell = ~cur_bit & prv_bit;

  always_comb begin
    unique case (mode)
      PM_RISE:   edge_match = rose;
      PM_FALL:   edge_match = fell;
      PM_EITHER: edge_match = rose | fell;
      default:   edge_match = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     latch_q <= 1'b0;
    else if (rearm) latch_q <= 1'b0;
    else            latch_q <= latch_q | edge_match;
  end

  always_comb begin
    unique case (mode)
      PM_TRUE:                     hit = 1'b1;
      PM_RISE, PM_FALL, PM_EITHER: hit = (latch_q & ~rearm) | edge_match;
      PM_HIGH:                     hit = cur_bit;
      PM_LOW:                      hit = ~cur_bit;
      PM_FALSE:                    hit = 1'b0;
      PM_EVENT:                    hit = cur_bit ^ prv_bit;
      default:                     hit = 1'b0;
    endcase
  end

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !rearm) |=> latch_q);
  // R5
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rearm) |-> !latch_q);
  // R3
  latch_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> ($past(mode) inside {PM_RISE, PM_FALL, PM_EITHER}));
endmodule

// File: rtl/pm_term_combine.sv
module pm_term_combine #(
  parameter int unsigned NSLICE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLICE-1:0] hits,
  input  logic [NSLICE-2:0] ends,
  output logic [NSLICE-1:0] term_irq,
  output logic              match_any
);
  logic [NSLICE-1:0] ep_eff, acc, term_d;

  for (genvar i = 0; i < NSLICE; i++) begin : g_chain
    if (i == NSLICE - 1) begin : g_last
      assign ep_eff[i] = 1'b1;
    end else begin : g_mid
      assign ep_eff[i] = ends[i];
    end
    if (i == 0) begin : g_first
      assign acc[i] = hits[i];
    end else begin : g_next
      assign acc[i] = ep_eff[i-1] ? hits[i] : (acc[i-1] & hits[i]);
    end
    assign term_d[i] = acc[i] & ep_eff[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_irq  <= '0;
      match_any <= 1'b0;
    end else begin
      term_irq  <= term_d;
      match_any <= |term_d;
    end
  end

  // R9
  match_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_any == (|term_irq));

  for (genvar i = 0; i < NSLICE; i++) begin : g_chk
    // R7
    closer_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_irq[i] |-> $past(hits[i]));
    if (i < NSLICE - 1) begin : g_ep
      // R7
      endpoint_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_irq[i] |-> $past(ends[i]));
    end
  end
endmodule

// File: rtl/pm_minterm_engine.sv
module pm_minterm_engine
  import pm_pkg::*;
#(
  parameter int unsigned NPINS  = 16,
  parameter int unsigned NSLICE = 8,
  parameter int unsigned SELW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPINS-1:0]            pin_in,
  input  logic [NSLICE*SELW-1:0]      cfg_sel,
  input  logic [NSLICE*PM_COND_W-1:0] cfg_cond,
  input  logic [NSLICE-2:0]           cfg_end,
  input  logic                        rearm,
  output logic [NSLICE-1:0]           term_irq,
  output logic                        match_any
);
  logic [NPINS-1:0]  pin_cur, pin_prev;
  logic [NSLICE-1:0] hits;

  pm_pin_sync #(.NPINS(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_in),
    .pin_cur  (pin_cur),
    .pin_prev (pin_prev)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    pm_slice #(.NPINS(NPINS), .SELW(SELW)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .rearm    (rearm),
      .pin_cur  (pin_cur),
      .pin_prev (pin_prev),
      .sel      (cfg_sel[s*SELW +: SELW]),
      .mode     (pm_cond_e'(cfg_cond[s*PM_COND_W +: PM_COND_W])),
      .hit      (hits[s])
    );
  end

  pm_term_combine #(.NSLICE(NSLICE)) u_terms (
    .clk       (clk),
    .rst_n     (rst_n),
    .hits      (hits),
    .ends      (cfg_end),
    .term_irq  (term_irq),
    .match_any (match_any)
  );
endmodule

// File: tb/tb_pm_minterm_engine.sv
`timescale 1ns/1ps
module tb_pm_minterm_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_in = '0;
  logic [31:0] cfg_sel = '0;
  logic [23:0] cfg_cond = {8{3'd6}};
  logic [6:0]  cfg_end = '1;
  logic        rearm = 1'b0;
  logic [7:0]  term_irq;
  logic        match_any;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_minterm_engine dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_sel(cfg_sel),
    .cfg_cond(cfg_cond), .cfg_end(cfg_end), .rearm(rearm),
    .term_irq(term_irq), .match_any(match_any)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (term_irq !== exp) begin
      n_bad++;
      $display("FAIL %s term_irq actual %h expected %h", req, term_irq, exp);
    end
    n_chk++;
    if (match_any !== (|exp)) begin
      n_bad++;
      $display("FAIL R9 (%s) match_any actual %b expected %b", req, match_any, |exp);
    end
  endtask

  task automatic set_slice(input int s, input int sel, input int cond);
    cfg_sel[s*4 +: 4]  = 4'(sel);
    cfg_cond[s*3 +: 3] = 3'(cond);
  endtask

  task automatic clean();
    cfg_cond = {8{3'd6}};
    cfg_end  = '1;
    cfg_sel  = '0;
    pin_in   = '0;
    tick(4);
    rearm = 1'b1;
    tick(1);
    rearm = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(2);
    check("R11", 8'h00);
    rst_n = 1'b1;
    tick(2);
    check("R11", 8'h00);
  endtask

  task automatic t_const_true();
    clean();
    set_slice(0, 0, 0);
    tick(1);
    check("R10/R1", 8'h01);
  endtask

  task automatic t_select_high();
    clean();
    set_slice(0, 5, 4);
    pin_in = 16'hFFDF;
    tick(3);
    check("R2", 8'h00);
    pin_in[5] = 1'b1;
    tick(2);
    check("R1", 8'h00);
    tick(1);
    check("R4/R1", 8'h01);
  endtask

  task automatic t_low();
    clean();
    set_slice(2, 9, 5);
    tick(1);
    check("R4", 8'h04);
    pin_in[9] = 1'b1;
    tick(2);
    check("R1", 8'h04);
    tick(1);
    check("R4", 8'h00);
  endtask

  task automatic t_sticky_and();
    clean();
    set_slice(0, 1, 4);
    set_slice(1, 2, 1);
    cfg_end[0] = 1'b0;
    pin_in[1] = 1'b1;
    tick(3);
    check("R7", 8'h00);
    pin_in[2] = 1'b1;
    tick(2);
    check("R1", 8'h00);
    tick(1);
    check("R7", 8'h02);
    pin_in[2] = 1'b0;
    tick(4);
    check("R5", 8'h02);
    pin_in[1] = 1'b0;
    tick(3);
    check("R7", 8'h00);
    pin_in[1] = 1'b1;
    tick(3);
    check("R5", 8'h02);
    rearm = 1'b1;
    tick(1);
    rearm = 1'b0;
    check("R5", 8'h00);
    tick(3);
    check("R5", 8'h00);
  endtask

  task automatic t_fall_either();
    clean();
    set_slice(3, 3, 2);
    set_slice(4, 3, 3);
    pin_in[3] = 1'b1;
    tick(3);
    check("R3", 8'h10);
    pin_in[3] = 1'b0;
    tick(3);
    check("R3", 8'h18);
  endtask

  task automatic t_event();
    clean();
    set_slice(5, 7, 7);
    pin_in[7] = 1'b1;
    tick(2);
    check("R6", 8'h00);
    tick(1);
    check("R6", 8'h20);
    tick(1);
    check("R6", 8'h00);
  endtask

  task automatic t_last_closes();
    clean();
    for (int s = 0; s < 7; s++) set_slice(s, 0, 0);
    set_slice(7, 0, 4);
    cfg_end = '0;
    tick(1);
    check("R8", 8'h00);
    pin_in[0] = 1'b1;
    tick(3);
    check("R8", 8'h80);
    set_slice(6, 0, 6);
    tick(1);
    check("R10", 8'h00);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_const_true();
    t_select_high();
    t_low();
    t_sticky_and();
    t_fall_either();
    t_event();
    t_last_closes();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule